// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Controller

This block keeps an EDO DRAM array alive. After reset it waits out the power-up pause, then runs a set of dummy refresh cycles in which the column strobe falls before the row strobe (CBR refresh). Only after those does it tell the rest of the memory subsystem that the array can be used. From then on it owes one CBR refresh per refresh interval. Each owed refresh is paid by borrowing the DRAM bus from the access sequencer through a request/grant pair. While it holds the grant it drives the row strobes of every bank, the column strobes and the write strobe itself.

The array uses its own internal row counter during CBR, so the controller produces no address. Refreshes that could not run because the grant was withheld are remembered and paid back-to-back once the bus is handed over. A sticky flag reports a backlog that grew beyond a set limit.

A self-refresh request parks the array with both strobes held low. When the request is removed, the controller waits out the post-exit precharge and runs a full catch-up burst of CBR cycles. Only after that burst does normal distributed refresh resume.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted, every row strobe and column strobe is high, the write strobe is high, and `ready_o`, `req_o` and `backlog_err_o` are low.
- R2: After reset is released, `req_o` stays low and the strobes stay idle for exactly T_PWRUP cycles. `req_o` rises in cycle T_PWRUP. Then exactly INIT_CYC CBR cycles are issued, and `ready_o` rises after the last of them and not before.
- R3: In every CBR cycle the column strobe falls T_CSR cycles before the row strobe. It stays low for as long as the row strobe is low. The write strobe is high at all times.
- R4: In a CBR cycle the row strobe is low for exactly T_RAS cycles. Refresh cycles that run back to back start every T_CSR+T_RAS+T_RP+1 cycles, so the row strobe is high for at least T_RP cycles between them.
- R5: While the array is ready and the grant is always given, CBR cycles begin exactly T_REFI cycles apart.
- R6: The strobes leave their idle level only while `grant_i` is high. Once raised, `req_o` stays high until the grant arrives. `req_o` falls once the owed work is done.
- R7: Refresh intervals that elapse while the grant is withheld are counted. When the grant comes, exactly that many CBR cycles run back to back.
- R8: `backlog_err_o` rises when the count of owed refreshes in normal operation exceeds BACKLOG_MAX. It then stays high until reset. A backlog equal to BACKLOG_MAX leaves it low.
- R9: A high `sr_req_i` on a ready array leads to self-refresh: the column strobe falls first, then the row strobe. Both stay low while the request is high and for at least T_SRAS cycles. If the request was already removed, the row strobe is low for exactly T_SRAS cycles. `ready_o` is low throughout.
- R10: After self-refresh, the row strobe stays high for at least T_RPS cycles. Then exactly BURST_CYC CBR cycles run with `ready_o` low, and `ready_o` returns after them.
- R11: The row strobes of all banks carry the same value in every cycle, and so do the column strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Bus handed over by the access sequencer |
| sr_req_i | input | 1 | Level request to hold the array in self-refresh |
| req_o | output | 1 | Bus wanted by this controller |
| ready_o | output | 1 | Array may be used by the access sequencer |
| ras_n_o | output | NUM_BANKS | Row strobes, active low, one per bank |
| cas_n_o | output | NUM_BANKS | Column strobes, active low |
| we_n_o | output | 1 | Write strobe, active low, kept high |
| backlog_err_o | output | 1 | Sticky flag: owed refreshes exceeded BACKLOG_MAX |

## Verification
The due cycles follow from the register path of each result:
- **Start-up request (R2):** the request is due exactly T_PWRUP cycles after reset release.
- **Back-to-back cycles (R4):** a row-strobe fall follows the previous one by T_CSR+T_RAS+T_RP+1 cycles.
- **Distributed refresh (R5):** one row-strobe fall is due per T_REFI cycles.
- **Self-refresh (R9, R10):** the row strobe is low for exactly T_SRAS cycles when the request is dropped early. The burst falls follow T_RPS+2 cycles after it rises.

A monitor samples the strobes one time unit after each falling clock edge and records when each fall and each rise happens. The directed tasks compare those recorded times with the counts above.

The backlog window is placed against the known refresh cadence. Grant is withheld for a span that holds exactly three interval ticks, and the count of row-strobe falls is taken before the next tick is due.

// File: rtl/drc_pkg.sv
`timescale 1ns/1ps
package drc_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE = 3'd0,
    ST_IDLE  = 3'd1,
    ST_REQ   = 3'd2,
    ST_CBR   = 3'd3,
    ST_SRE   = 3'd4,
    ST_SR    = 3'd5,
    ST_SRX   = 3'd6
  } ctl_state_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_PRE   = 2'd3
  } cbr_phase_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drc_refi_timer.sv
`timescale 1ns/1ps
module drc_refi_timer #(
  parameter int T_REFI = 1950
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  localparam int TW = $clog2(T_REFI + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == TW'(T_REFI - 1));

  always_comb begin
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/drc_cbr_seq.sv
`timescale 1ns/1ps
module drc_cbr_seq import drc_pkg::*; #(
  parameter int T_CSR = 1,
  parameter int T_RAS = 8,
  parameter int T_RP  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic done_o
);

  localparam int CMAX = max2(max2(T_CSR, T_RAS), T_RP);
  localparam int CW   = $clog2(CMAX + 1);
  localparam int LW   = $clog2(T_RAS + 2);

  cbr_phase_t    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_o  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_SETUP;
          cnt_d   = CW'(T_CSR - 1);
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACT;
          cnt_d   = CW'(T_RAS - 1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_ACT: begin
        if (cnt_q == '0) begin
          phase_d = PH_PRE;
          cnt_d   = CW'(T_RP - 1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: begin
        if (cnt_q == '0) begin
          done_o  = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
    endcase
  end

  assign cnt_en = (phase_q != PH_IDLE) || start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign ras_n_o = (phase_q != PH_ACT);
  assign cas_n_o = !((phase_q == PH_SETUP) || (phase_q == PH_ACT));

  // checker: width of the row strobe low pulse
  logic [LW-1:0] lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   lo_cnt <= '0;
    else if (ras_n_o)              lo_cnt <= '0;
    else if (lo_cnt != LW'(T_RAS + 1)) lo_cnt <= lo_cnt + LW'(1);
  end

  AST_CAS_LEADS_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o)); // R3

  AST_RAS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_cnt == LW'(T_RAS))); // R4

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (phase_q == PH_IDLE)); // R4

endmodule

// File: rtl/drc_owe_ledger.sv
`timescale 1ns/1ps
module drc_owe_ledger #(
  parameter int OW          = 12,
  parameter int BACKLOG_MAX = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          done_i,
  input  logic          load_i,
  input  logic [OW-1:0] load_val_i,
  input  logic          chk_i,
  output logic [OW-1:0] owed_o,
  output logic          err_o
);

  logic [OW-1:0] owed_q, owed_d;
  logic          err_q, err_d;

  always_comb begin
    owed_d = owed_q;
    if (load_i) begin
      owed_d = load_val_i;
    end else if (tick_i && !done_i) begin
      if (owed_q != {OW{1'b1}}) owed_d = owed_q + OW'(1);
    end else if (done_i && !tick_i) begin
      if (owed_q != '0) owed_d = owed_q - OW'(1);
    end
    err_d = err_q || (chk_i && (owed_q > OW'(BACKLOG_MAX)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owed_q <= '0;
      err_q  <= 1'b0;
    end else begin
      owed_q <= owed_d;
      err_q  <= err_d;
    end
  end

  assign owed_o = owed_q;
  assign err_o  = err_q;

  AST_DONE_WAS_OWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (owed_q != '0)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R8

endmodule

// File: rtl/dram_refresh_ctrl.sv
`timescale 1ns/1ps
module dram_refresh_ctrl import drc_pkg::*; #(
  parameter int NUM_BANKS   = 2,
  parameter int T_PWRUP     = 25000,
  parameter int T_REFI      = 1950,
  parameter int INIT_CYC    = 8,
  parameter int BURST_CYC   = 2048,
  parameter int T_CSR       = 1,
  parameter int T_RAS       = 8,
  parameter int T_RP        = 6,
  parameter int T_SRAS      = 12500,
  parameter int T_RPS       = 14,
  parameter int BACKLOG_MAX = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 grant_i,
  input  logic                 sr_req_i,
  output logic                 req_o,
  output logic                 ready_o,
  output logic [NUM_BANKS-1:0] ras_n_o,
  output logic [NUM_BANKS-1:0] cas_n_o,
  output logic                 we_n_o,
  output logic                 backlog_err_o
);

  localparam int OWE_MAX = max2(max2(BURST_CYC, INIT_CYC), BACKLOG_MAX + 1);
  localparam int OW      = $clog2(OWE_MAX + 1);
  localparam int TMAX    = max2(max2(T_PWRUP, T_SRAS), max2(T_RPS, T_CSR));
  localparam int TW      = $clog2(TMAX + 1);
  localparam int HW      = $clog2(T_RP + 1);

  ctl_state_t    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          init_q, init_d;
  logic          burst_q, burst_d;

  logic          start, load, tick, seq_done, seq_ras_n, seq_cas_n;
  logic [OW-1:0] load_val, owed;
  logic          in_sr, ras_n_int, cas_n_int;

  assign in_sr   = (state_q == ST_SRE) || (state_q == ST_SR) || (state_q == ST_SRX);
  assign ready_o = !init_q && !burst_q && !in_sr;
  assign req_o   = (state_q != ST_PAUSE) && (state_q != ST_IDLE);
  assign we_n_o  = 1'b1;

  drc_refi_timer #(.T_REFI(T_REFI)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ready_o),
    .tick_o (tick)
  );

  drc_cbr_seq #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ras_n_o (seq_ras_n),
    .cas_n_o (seq_cas_n),
    .done_o  (seq_done)
  );

  drc_owe_ledger #(.OW(OW), .BACKLOG_MAX(BACKLOG_MAX)) i_ledger (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .done_i     (seq_done),
    .load_i     (load),
    .load_val_i (load_val),
    .chk_i      (!init_q && !burst_q),
    .owed_o     (owed),
    .err_o      (backlog_err_o)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_q;
    init_d   = init_q;
    burst_d  = burst_q;
    start    = 1'b0;
    load     = 1'b0;
    load_val = OW'(INIT_CYC);
    case (state_q)
      ST_PAUSE: begin
        if (tmr_q == '0) begin
          state_d = ST_REQ;
          load    = 1'b1;
        end else begin
          tmr_d = tmr_q - TW'(1);
        end
      end
      ST_IDLE: begin
        if ((owed != '0) || sr_req_i) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (owed == '0) begin
          init_d  = 1'b0;
          burst_d = 1'b0;
        end
        if (grant_i) begin
          if (owed != '0) begin
            start   = 1'b1;
            state_d = ST_CBR;
          end else if (sr_req_i) begin
            state_d = ST_SRE;
            tmr_d   = TW'(T_CSR - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_CBR: begin
        if (seq_done) state_d = ST_REQ;
      end
      ST_SRE: begin
        if (tmr_q == '0) begin
          state_d = ST_SR;
          tmr_d   = TW'(T_SRAS - 1);
        end else begin
          tmr_d = tmr_q - TW'(1);
        end
      end
      ST_SR: begin
        if (tmr_q != '0) begin
          tmr_d = tmr_q - TW'(1);
        end else if (!sr_req_i) begin
          state_d = ST_SRX;
          tmr_d   = TW'(T_RPS - 1);
        end
      end
      ST_SRX: begin
        if (tmr_q == '0) begin
          state_d  = ST_REQ;
          load     = 1'b1;
          load_val = OW'(BURST_CYC);
          burst_d  = 1'b1;
        end else begin
          tmr_d = tmr_q - TW'(1);
        end
      end
      default: state_d = ST_PAUSE;
    endcase
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      tmr_q   <= TW'(T_PWRUP - 1);
      init_q  <= 1'b1;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      init_q  <= init_d;
      burst_q <= burst_d;
    end
  end

  // strobe selection
  always_comb begin
    case (state_q)
      ST_CBR: begin
        ras_n_int = seq_ras_n;
        cas_n_int = seq_cas_n;
      end
      ST_SRE: begin
        ras_n_int = 1'b1;
        cas_n_int = 1'b0;
      end
      ST_SR: begin
        ras_n_int = 1'b0;
        cas_n_int = 1'b0;
      end
      default: begin
        ras_n_int = 1'b1;
        cas_n_int = 1'b1;
      end
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign ras_n_o[b] = ras_n_int;
    assign cas_n_o[b] = cas_n_int;
  end

  // checker: row strobe high time before each fall
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hi_cnt <= '0;
    else if (!ras_n_int)          hi_cnt <= '0;
    else if (hi_cnt != HW'(T_RP)) hi_cnt <= hi_cnt + HW'(1);
  end

  AST_PRECHARGE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_int) |-> (hi_cnt == HW'(T_RP))); // R4

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !grant_i) |=> req_o); // R6

  AST_BUS_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_int || !cas_n_int) |-> grant_i); // R6

  AST_SR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SR) && sr_req_i) |=> !ras_n_int); // R9

endmodule

// File: tb/test_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module test_dram_refresh_ctrl;

  localparam int PW   = 200;
  localparam int RI   = 100;
  localparam int IC   = 8;
  localparam int BC   = 20;
  localparam int CSR  = 1;
  localparam int RAS  = 8;
  localparam int RP   = 6;
  localparam int SRAS = 60;
  localparam int RPS  = 14;
  localparam int BL   = 3;
  localparam int PER  = CSR + RAS + RP + 1;

  logic       clk, rst_n, grant_i, sr_req, gnt_en;
  logic       req_o, ready_o, we_n_o, err_o;
  logic [1:0] ras_n_o, cas_n_o;

  int nchk = 0, nfail = 0;
  int cyc = 0, nfall = 0, fall_t = 0, fall_prev = 0, rise_t = 0;
  int last_lo = 0, last_gap = 0;
  int bad_we = 0, bad_bank = 0, bad_csr = 0, bad_chr = 0, bad_gnt = 0;
  logic p_ras, p_cas;

  dram_refresh_ctrl #(
    .NUM_BANKS(2), .T_PWRUP(PW), .T_REFI(RI), .INIT_CYC(IC), .BURST_CYC(BC),
    .T_CSR(CSR), .T_RAS(RAS), .T_RP(RP), .T_SRAS(SRAS), .T_RPS(RPS),
    .BACKLOG_MAX(BL)
  ) i_dram_refresh_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .grant_i(grant_i), .sr_req_i(sr_req),
    .req_o(req_o), .ready_o(ready_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .backlog_err_o(err_o)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  // access sequencer model: grants whenever allowed and asked
  initial begin
    grant_i = 1'b0;
    forever begin
      @(negedge clk);
      grant_i = gnt_en && req_o;
    end
  end

  // strobe monitor
  initial begin
    p_ras = 1'b1;
    p_cas = 1'b1;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        cyc++;
        if (p_ras && !ras_n_o[0]) begin
          fall_prev = fall_t;
          fall_t    = cyc;
          last_gap  = cyc - rise_t;
          nfall++;
          if (p_cas !== 1'b0) bad_csr++;
        end
        if (!p_ras && ras_n_o[0]) begin
          rise_t  = cyc;
          last_lo = cyc - fall_t;
        end
        if (!ras_n_o[0] && cas_n_o[0]) bad_chr++;
        if ((!ras_n_o[0] || !cas_n_o[0]) && !grant_i) bad_gnt++;
        if (we_n_o !== 1'b1) bad_we++;
        if ((ras_n_o[1] !== ras_n_o[0]) || (cas_n_o[1] !== cas_n_o[0])) bad_bank++;
        p_ras = ras_n_o[0];
        p_cas = cas_n_o[0];
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_req_low();
    for (int i = 0; i < 500 && req_o; i++) step();
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    gnt_en = 1'b1;
    sr_req = 1'b0;
    repeat (3) step();
    chk("R1 row strobes idle", int'(ras_n_o), 3);
    chk("R1 column strobes idle", int'(cas_n_o), 3);
    chk("R1 write strobe high", int'(we_n_o), 1);
    chk("R1 ready low", int'(ready_o), 0);
    chk("R1 req low", int'(req_o), 0);
    chk("R1 err low", int'(err_o), 0);
  endtask

  task automatic t_init();
    int n;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    do begin
      step();
      n++;
    end while (!req_o && n < 10000);
    chk("R2 request after pause", n, PW);
    chk("R2 no strobe during pause", nfall, 0);
    for (int i = 0; i < 2000 && !ready_o; i++) begin
      step();
      if (!ready_o && nfall > IC) break;
    end
    chk("R2 ready after init cycles", int'(ready_o), 1);
    chk("R2 init cycle count", nfall, IC);
    chk("R4 back to back period", fall_t - fall_prev, PER);
    chk("R4 row strobe low width", last_lo, RAS);
    chk("R6 bus released after init", int'(req_o), 0);
    chk("R3 column strobe leads", bad_csr, 0);
  endtask

  task automatic t_distrib();
    int n0 = nfall;
    for (int i = 0; i < 600 && nfall < n0 + 3; i++) step();
    chk("R5 distributed spacing", fall_t - fall_prev, RI);
    chk("R5 ready kept", int'(ready_o), 1);
  endtask

  task automatic t_backlog();
    int n0;
    wait_req_low();
    gnt_en = 1'b0;
    n0 = nfall;
    repeat (294) step();
    chk("R6 no strobe without grant", nfall - n0, 0);
    chk("R6 request held", int'(req_o), 1);
    gnt_en = 1'b1;
    n0 = nfall;
    repeat (60) step();
    chk("R7 owed cycles paid", nfall - n0, 3);
    chk("R7 paid back to back", fall_t - fall_prev, PER);
    chk("R8 no error at limit", int'(err_o), 0);
    chk("R6 request dropped", int'(req_o), 0);
  endtask

  task automatic t_selfref();
    int n0;
    wait_req_low();
    sr_req = 1'b1;
    for (int i = 0; i < 50 && ras_n_o[0]; i++) step();
    chk("R9 entered self refresh", int'(ras_n_o[0]), 0);
    chk("R9 ready low in self refresh", int'(ready_o), 0);
    chk("R9 column strobe low", int'(cas_n_o[0]), 0);
    repeat (20) step();
    sr_req = 1'b0;
    for (int i = 0; i < 200 && !ras_n_o[0]; i++) step();
    chk("R9 self refresh low width", last_lo, SRAS);
    n0 = nfall;
    for (int i = 0; i < 100 && nfall == n0; i++) step();
    chk("R10 post exit precharge", int'(last_gap >= RPS), 1);
    chk("R10 ready low in burst", int'(ready_o), 0);
    for (int i = 0; i < 2000 && !ready_o; i++) step();
    chk("R10 ready after burst", int'(ready_o), 1);
    chk("R10 burst count", nfall - n0, BC);
  endtask

  task automatic t_error();
    wait_req_low();
    gnt_en = 1'b0;
    repeat (RI * 5) step();
    chk("R8 error above limit", int'(err_o), 1);
    gnt_en = 1'b1;
    repeat (150) step();
    chk("R8 error sticky", int'(err_o), 1);
    chk("R7 backlog cleared", int'(req_o), 0);
  endtask

  task automatic t_final();
    chk("R3 write strobe always high", bad_we, 0);
    chk("R3 column strobe leads", bad_csr, 0);
    chk("R3 column strobe held", bad_chr, 0);
    chk("R6 strobes only with grant", bad_gnt, 0);
    chk("R11 banks together", bad_bank, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_distrib();
    t_backlog();
    t_selfref();
    t_error();
    t_final();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule